// File: doc/BRIEF.md
# Radix-3 Lookahead Incrementer

This block adds a single carry-in bit to an unsigned vector. Every stage is combinational. The second operand is always zero, so no bit ever generates a carry. A bit passes a carry upward only when it is one. The carry problem then reduces to AND terms of the operand bits.

The structure is built from three-bit groups. Each lookahead unit takes three propagate signals and one carry-in. It returns the three carries that enter its children and a group propagate for its parent. Units are nested level by level into a radix-3 tree:

- 3 bits need one level.
- 27 bits need three levels.
- 81 bits need four levels.

A carry crossing a group boundary comes from a higher-level unit, not from a ripple through the lower groups.

When the width is not a power of three, the operand is zero-padded up to the next power. Synthesis then removes the padded cells and the lookahead terms above the top result bit. The carry-out is taken at the position just above the top result bit. Tying the carry-in high gives a plain increment.

Top module: `radix3_incrementer`

## Requirements
- R1: `result` equals (`op_a` + `carry_in`) modulo 2^WIDTH for every input combination.
- R2: With `carry_in` = 0, `op_a` has no effect beyond being copied: `result` equals `op_a` and `carry_out` is 0.
- R3: `carry_out` is 1 exactly when `op_a` is all ones and `carry_in` is 1. In that case `result` is all zeros.
- R4: With `carry_in` = 1, result bit i is the inverse of `op_a` bit i when bits 0 to i-1 of `op_a` are all one. Otherwise it equals `op_a` bit i. When `op_a` bit 0 is 0, only bit 0 changes.
- R5: WIDTH may be any value of 1 or more. A width that is not a power of three, such as 37, behaves as a true WIDTH-bit incrementer, with `carry_out` taken from the carry into bit WIDTH.
- R6: Carries crossing group boundaries at multiples of 3, 9 and 27 bits are correct. With the lowest n bits of `op_a` all one and bit n zero, `result` is `op_a` with bits 0 to n-1 cleared and bit n set.
- R7: The block holds no state. Outputs follow the inputs within the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand to be incremented |
| carry_in | input | 1 | Value added at bit 0; tie to 1 for a plain increment |
| result | output | WIDTH | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry leaving the top result bit |

## Verification
Two functions can fall in the same evaluation: the wrap of the result to zero and the raising of the carry-out. Both come from the same all-ones operand, but through separate paths. The wrap comes through the leaf cells, and the carry-out comes from the root propagate or from the pruned-position carry. The bench provokes this with an all-ones operand at the 37-bit pruned width, and also with operands that are all ones except for one zero just below a group boundary. It judges the pair {`carry_out`, `result`} against an unbounded sum computed in the bench. A mismatch in either half is reported, so a carry-out raised without the matching wrap, or a wrap with no carry-out, is caught.

// File: rtl/inc_pkg.sv
package inc_pkg;

  function automatic int pow3(input int e);
    int v;
    v = 1;
    for (int i = 0; i < e; i++) v = v * 3;
    return v;
  endfunction

  // smallest number of radix-3 levels covering w bits (at least one)
  function automatic int tree_levels(input int w);
    int l;
    int span;
    l = 1;
    span = 3;
    while (span < w) begin
      l = l + 1;
      span = span * 3;
    end
    return l;
  endfunction

  // start index of level k in a flat vector holding all levels of a
  // tree with np leaves (level 0 = leaves, each level a third of the last)
  function automatic int level_base(input int np, input int k);
    int b;
    int n;
    b = 0;
    n = np;
    for (int i = 0; i < k; i++) begin
      b = b + n;
      n = n / 3;
    end
    return b;
  endfunction

endpackage

// File: rtl/inc_cell3.sv
module inc_cell3 (
  input  logic [2:0] x,
  input  logic [2:0] cy,
  output logic [2:0] s,
  output logic [2:0] p
);
  for (genvar i = 0; i < 3; i++) begin : g_bit
    assign s[i] = x[i] ^ cy[i];
    assign p[i] = x[i];
  end

  always_comb begin
    if (!cy[0]) begin
      AST_CELL_HOLD: assert (s[0] == x[0]);   // R2
    end
  end
endmodule

// File: rtl/inc_lau3.sv
module inc_lau3 (
  input  logic [2:0] kid_p,
  input  logic       grp_cin,
  output logic [2:0] kid_cy,
  output logic       grp_p
);
  assign kid_cy[0] = grp_cin;
  assign kid_cy[1] = kid_p[0] & grp_cin;
  assign kid_cy[2] = kid_p[1] & kid_p[0] & grp_cin;
  assign grp_p     = kid_p[2] & kid_p[1] & kid_p[0];

  always_comb begin
    if (kid_cy[2]) begin
      AST_CARRY_CHAIN: assert (kid_cy[1] && kid_cy[0]);   // R6
    end
    if (!grp_cin) begin
      AST_NO_CARRY_IN: assert (kid_cy == 3'b000);         // R2
    end
  end
endmodule

// File: rtl/radix3_incrementer.sv
module radix3_incrementer #(
  parameter int WIDTH = 27
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  import inc_pkg::*;

  localparam int LV  = tree_levels(WIDTH);
  localparam int NP  = pow3(LV);
  localparam int TOT = level_base(NP, LV + 1);
  localparam int ROOT = TOT - 1;

  logic [NP-1:0]  a_pad;
  logic [NP-1:0]  s_pad;
  logic [TOT-1:0] prop;   // propagate of every node, all levels
  logic [TOT-1:0] cy;     // carry entering every node, all levels
  logic           root_cout;

  assign a_pad    = NP'(op_a);
  assign cy[ROOT] = carry_in;

  // leaf cells: three bits each
  for (genvar j = 0; j < NP / 3; j++) begin : g_leaf
    inc_cell3 u_cell (
      .x  (a_pad[3*j +: 3]),
      .cy (cy[3*j +: 3]),
      .s  (s_pad[3*j +: 3]),
      .p  (prop[3*j +: 3])
    );
  end

  // lookahead units, one level of the tree per iteration
  for (genvar k = 1; k <= LV; k++) begin : g_lvl
    localparam int UNITS  = NP / pow3(k);
    localparam int B_KID  = level_base(NP, k - 1);
    localparam int B_SELF = level_base(NP, k);
    for (genvar j = 0; j < UNITS; j++) begin : g_unit
      inc_lau3 u_lau (
        .kid_p  (prop[B_KID + 3*j +: 3]),
        .grp_cin(cy[B_SELF + j]),
        .kid_cy (cy[B_KID + 3*j +: 3]),
        .grp_p  (prop[B_SELF + j])
      );
    end
  end

  assign root_cout = prop[ROOT] & carry_in;
  assign result    = s_pad[WIDTH-1:0];

  if (WIDTH == NP) begin : g_full
    assign carry_out = root_cout;
  end else begin : g_pruned
    assign carry_out = cy[WIDTH];
  end

  always_comb begin
    if (carry_out) begin
      AST_WRAP_ZERO: assert (result == '0);                    // R3
    end
    if (!carry_in) begin
      AST_PASS_THROUGH: assert (result == op_a && !carry_out); // R2
    end
    if (carry_in && !op_a[0]) begin
      AST_LOW_ZERO: assert (result == (op_a | WIDTH'(1)));     // R4
    end
  end
endmodule

// File: tb/radix3_incrementer_test.sv
module radix3_incrementer_test;
  localparam int W = 37;

  logic         clk;
  logic [W-1:0] op_a;
  logic         carry_in;
  logic [W-1:0] result;
  logic         carry_out;

  int n_checks;
  int n_fail;
  bit finished;
  logic [63:0] rng;

  radix3_incrementer #(.WIDTH(W)) uut (
    .op_a     (op_a),
    .carry_in (carry_in),
    .result   (result),
    .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic apply_check(input logic [W-1:0] a, input logic ci, input string req);
    logic [W:0] exp;
    @(posedge clk);
    op_a     = a;
    carry_in = ci;
    @(negedge clk);
    exp = {1'b0, a} + {{W{1'b0}}, ci};
    n_checks++;
    if ({carry_out, result} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h ci=%b actual=%h expected=%h", req, a, ci,
               {carry_out, result}, exp);
    end
  endtask

  task automatic t_start_state;
    // R7: zero inputs applied from time zero give zero outputs at once
    #1;
    n_checks++;
    if (result !== '0 || carry_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R7: actual=%h expected=0", {carry_out, result});
    end
  endtask

  task automatic t_no_carry;
    apply_check('0, 1'b0, "R2");
    apply_check({W{1'b1}}, 1'b0, "R2");
    apply_check(37'h15_5555_5555, 1'b0, "R2");
    apply_check(37'h0A_AAAA_AAAA, 1'b0, "R2");
  endtask

  task automatic t_wrap;
    apply_check({W{1'b1}}, 1'b1, "R3");
    apply_check({1'b0, {(W-1){1'b1}}}, 1'b1, "R5");
    apply_check({1'b1, 1'b0, {(W-2){1'b1}}}, 1'b1, "R3");
  endtask

  task automatic t_walk_ones;
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] a;
      a = '1;
      a = a >> (W - i);
      if (i == 0) a = '0;
      apply_check(a, 1'b1, "R4");
    end
  endtask

  task automatic t_group_edges;
    int edges[6] = '{2, 3, 8, 9, 26, 27};
    foreach (edges[e]) begin
      logic [W-1:0] a;
      a = '1;
      a = a >> (W - edges[e]);
      a = a | (37'h1F << (edges[e] + 1));
      apply_check(a, 1'b1, "R6");
    end
  endtask

  task automatic t_even_low;
    apply_check(37'h12_3456_789A, 1'b1, "R4");
    apply_check(37'h1F_FFFF_FFFE, 1'b1, "R4");
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      apply_check(rng[W-1:0], rng[40], "R1");
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 1'b0;
    rng      = 64'h9E37_79B9_7F4A_7C15;
    op_a     = '0;
    carry_in = 1'b0;
    t_start_state();
    t_no_carry();
    t_wrap();
    t_walk_ones();
    t_group_edges();
    t_even_low();
    t_random();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R7: watchdog expired, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule